// File: doc/BRIEF.md
# SYSREF Pulse Generator

This block derives a SYSREF timing line from a fast clock. A power-of-two pre-divider produces a clock enable. A 12-bit programmable divider follows it and produces a periodic level. The output stage then picks one of three behaviours. It can pass the divided level through without interruption. It can release a burst of a programmed number of divider pulses after each request edge. It can repeat a synchronized request input directly and skip the divider.

In burst mode the divider keeps running and a counter gates its output. Every burst pulse therefore has exactly the divider's high time and period. A burst starts only at the beginning of a divider period, so its first pulse is never clipped. The request input is asynchronous and goes through a two-stage synchronizer. A clear control holds the internal request low in every mode except repeater mode. The divide setting is screened: an odd value, which gives a duty cycle below one half, is taken only while the delay-bypass flag is set. Otherwise the last accepted value stays in force.

Top module: `sysref_pulse_gen`

## Requirements
- R1: With mode 0 (continuous) and an accepted divide value D of 2 or more, the output has a period of P*D clock cycles and a high time of P*floor(D/2) cycles. P is 2 raised to the pre-divide select (1, 2, 4 or 8).
- R2: An accepted divide value of 0 or 1 acts as divide-by-1. The output then has a period of P cycles and is high for one cycle per period.
- R3: A divide value with bit 0 set is accepted only while dly_bypass is high. Otherwise the previously accepted value is kept. After reset the accepted value is 32.
- R4: With mode 1 (burst), a rising edge of the synchronized request makes the block emit exactly N pulses, where N is pulse_cnt. Each pulse has the divider's high time and period, and the first pulse is full width.
- R5: In burst mode a pulse count of 0 produces no pulses.
- R6: A request edge that arrives while a burst is armed or running is ignored and does not lengthen the burst.
- R7: While req_clr is high, request edges have no effect in burst mode.
- R8: With mode 2 (repeater), sysref_out equals req_in delayed by three clock cycles. req_clr has no effect in this mode.
- R9: With mode 3 (off), sysref_out is held low.
- R10: While rst_n is low, sysref_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 1 | Asynchronous SYSREF request |
| req_clr | input | 1 | Holds the internal request low (not in repeater mode) |
| mode | input | 2 | 0 continuous, 1 burst, 2 repeater, 3 off |
| pulse_cnt | input | 4 | Number of pulses per burst |
| div_val | input | 12 | Requested main divide value |
| pre_sel | input | 2 | Pre-divide select, divide by 2**pre_sel |
| dly_bypass | input | 1 | Delay bypass flag; permits odd divide values |
| sysref_out | output | 1 | SYSREF output |

## Verification
Two events can land on the same cycle: a request edge, and the start of a divider period that launches or ends a burst. A second request can also arrive while a burst is still running. The bench sends a second request a few cycles after the first, so it falls inside the running burst. It then counts rising edges and high cycles across the whole window. The window must show exactly N pulses of the divider's width, with no extra pulse and no truncated first pulse. The bench also sweeps all pre-divide selects against a set of even, odd and degenerate divide values. It compares each measured high time and period with the arithmetic from R1 and R2.

// File: rtl/sysref_pg_pkg.sv
package sysref_pg_pkg;
  localparam int SR_DIV_W = 12;
  localparam int SR_CNT_W = 4;
  localparam int SR_PRE_W = 2;
  localparam logic [SR_DIV_W-1:0] SR_DIV_RST = 12'h020;

  typedef enum logic [1:0] {
    SR_CONT   = 2'd0,
    SR_BURST  = 2'd1,
    SR_REPEAT = 2'd2,
    SR_OFF    = 2'd3
  } sr_mode_e;
endpackage

// File: rtl/sysref_req_sync.sv
module sysref_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic req_clr,
  output logic req_sync,
  output logic req_rise
);
  logic [STAGES-1:0] sh_q;
  logic              gated;
  logic              gated_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= req_in;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[i] <= 1'b0;
        else        sh_q[i] <= sh_q[i-1];
      end
    end
  endgenerate

  assign req_sync = sh_q[STAGES-1];
  assign gated    = req_sync & ~req_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gated_q <= 1'b0;
    else        gated_q <= gated;
  end

  assign req_rise = gated & ~gated_q;
endmodule

// File: rtl/sysref_clkdiv.sv
module sysref_clkdiv #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [DIV_W-1:0] div_acc,
  output logic             level,
  output logic             period_start
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W:0]      pre_n;
  logic [PC_W-1:0]    pc_q, pc_d;
  logic [DIV_W-1:0]   dc_q, dc_d;
  logic [DIV_W-1:0]   d_eff;
  logic [DIV_W-1:0]   half;
  logic               pre_wrap;

  assign pre_n    = {{PC_W{1'b0}}, 1'b1} << pre_sel;
  assign d_eff    = (div_acc == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_acc;
  assign half     = d_eff >> 1;
  assign pre_wrap = ({1'b0, pc_q} >= (pre_n - 1'b1));

  always_comb begin
    pc_d = pc_q;
    dc_d = dc_q;
    if (pre_wrap) begin
      pc_d = '0;
      if (dc_q >= (d_eff - 1'b1)) dc_d = '0;
      else                        dc_d = dc_q + 1'b1;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      dc_q <= '0;
    end else begin
      pc_q <= pc_d;
      dc_q <= dc_d;
    end
  end

  assign period_start = (pc_q == '0) && (dc_q == '0);
  assign level = (d_eff < 2) ? (pc_q == '0) : (dc_q < half);
endmodule

// File: rtl/sysref_burst.sv
module sysref_burst #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req_rise,
  input  logic             period_start,
  input  logic [CNT_W-1:0] pulse_cnt,
  output logic             armed,
  output logic             active,
  output logic             start,
  output logic             pass
);
  logic             armed_d, active_d;
  logic [CNT_W-1:0] n_q, n_d, left_q, left_d;
  logic             last;

  assign start = armed & period_start & (n_q != '0);
  assign last  = active & period_start & (left_q == '0);
  assign pass  = start | (active & ~last);

  always_comb begin
    armed_d  = armed;
    active_d = active;
    n_d      = n_q;
    left_d   = left_q;
    if (!enable) begin
      armed_d  = 1'b0;
      active_d = 1'b0;
    end else begin
      if (req_rise && !armed && !active && (pulse_cnt != '0)) begin
        armed_d = 1'b1;
        n_d     = pulse_cnt;
      end
      if (start) begin
        armed_d  = 1'b0;
        active_d = 1'b1;
        left_d   = n_q - 1'b1;
      end else if (active && period_start) begin
        if (left_q == '0) active_d = 1'b0;
        else              left_d   = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      active <= 1'b0;
      n_q    <= '0;
      left_q <= '0;
    end else begin
      armed  <= armed_d;
      active <= active_d;
      n_q    <= n_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/sysref_pulse_gen.sv
module sysref_pulse_gen
  import sysref_pg_pkg::*;
#(
  parameter int DIV_W       = SR_DIV_W,
  parameter int CNT_W       = SR_CNT_W,
  parameter int PRE_W       = SR_PRE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_in,
  input  logic             req_clr,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic [DIV_W-1:0] div_val,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic             dly_bypass,
  output logic             sysref_out
);
  logic [DIV_W-1:0] div_acc;
  logic             acc_en;
  logic             level, period_start;
  logic             req_sync, req_rise;
  logic             burst_armed, burst_active, burst_start, burst_pass;
  logic             out_d;
  sr_mode_e         mode_e;

  assign mode_e = sr_mode_e'(mode);
  assign acc_en = ~div_val[0] | dly_bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_acc <= DIV_W'(SR_DIV_RST);
    else if (acc_en) div_acc <= div_val;
  end

  sysref_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (req_in),
    .req_clr  (req_clr),
    .req_sync (req_sync),
    .req_rise (req_rise)
  );

  sysref_clkdiv #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .pre_sel      (pre_sel),
    .div_acc      (div_acc),
    .level        (level),
    .period_start (period_start)
  );

  sysref_burst #(.CNT_W(CNT_W)) u_burst (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (mode_e == SR_BURST),
    .req_rise     (req_rise),
    .period_start (period_start),
    .pulse_cnt    (pulse_cnt),
    .armed        (burst_armed),
    .active       (burst_active),
    .start        (burst_start),
    .pass         (burst_pass)
  );

  always_comb begin
    case (mode_e)
      SR_CONT:   out_d = level;
      SR_BURST:  out_d = level & burst_pass;
      SR_REPEAT: out_d = req_sync;
      default:   out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sysref_out <= 1'b0;
    else        sysref_out <= out_d;
  end
endmodule

// File: rtl/sysref_pulse_gen_chk.sv
module sysref_pulse_gen_chk #(
  parameter int DIV_W = 12,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_in,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic [DIV_W-1:0] div_val,
  input logic             dly_bypass,
  input logic [DIV_W-1:0] div_acc,
  input logic             req_rise,
  input logic             burst_armed,
  input logic             burst_active,
  input logic             burst_start,
  input logic             burst_pass,
  input logic             sysref_out
);
  logic [1:0] age;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign live = (age == 2'd3);

  assert_odd_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !dly_bypass && div_val[0]) |=> $stable(div_acc));

  assert_burst_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode == 2'd1 && !burst_pass) |=> !sysref_out);

  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode == 2'd1 && pulse_cnt == '0 && !burst_armed && !burst_active && req_rise)
      |=> !burst_armed);

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $rose(burst_armed)) |-> $past(!burst_active && !burst_armed));

  assert_start_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && burst_start) |=> burst_active);

  assert_repeat_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode) == 2'd2) |-> (sysref_out == $past(req_in, 3)));

  assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode == 2'd3) |=> !sysref_out);
endmodule

bind sysref_pulse_gen sysref_pulse_gen_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_in       (req_in),
  .mode         (mode),
  .pulse_cnt    (pulse_cnt),
  .div_val      (div_val),
  .dly_bypass   (dly_bypass),
  .div_acc      (div_acc),
  .req_rise     (req_rise),
  .burst_armed  (burst_armed),
  .burst_active (burst_active),
  .burst_start  (burst_start),
  .burst_pass   (burst_pass),
  .sysref_out   (sysref_out)
);

// File: tb/sysref_pulse_gen_test.sv
`timescale 1ns/1ps
module sysref_pulse_gen_test;
  logic        clk;
  logic        rst_n;
  logic        req_in;
  logic        req_clr;
  logic [1:0]  mode;
  logic [3:0]  pulse_cnt;
  logic [11:0] div_val;
  logic [1:0]  pre_sel;
  logic        dly_bypass;
  logic        sysref_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  sysref_pulse_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in     (req_in),
    .req_clr    (req_clr),
    .mode       (mode),
    .pulse_cnt  (pulse_cnt),
    .div_val    (div_val),
    .pre_sel    (pre_sel),
    .dly_bypass (dly_bypass),
    .sysref_out (sysref_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int hi, output int per);
    int lo;
    int guard;
    hi = 0; lo = 0; guard = 0;
    @(negedge clk);
    while (sysref_out && guard < 4000) begin @(negedge clk); guard++; end
    while (!sysref_out && guard < 4000) begin @(negedge clk); guard++; end
    while (sysref_out && guard < 4000) begin hi++; @(negedge clk); guard++; end
    while (!sysref_out && guard < 4000) begin lo++; @(negedge clk); guard++; end
    per = hi + lo;
  endtask

  task automatic run_window(input int win, input int a0, input int a1,
                            input int b0, input int b1,
                            output int rises, output int highs);
    bit prev;
    rises = 0; highs = 0;
    prev = sysref_out;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (sysref_out) highs++;
      if (sysref_out && !prev) rises++;
      prev = sysref_out;
      req_in = ((i >= a0) && (i < a1)) || ((i >= b0) && (i < b1));
    end
    req_in = 1'b0;
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    int hi, per, rises, highs, pre, de, exp_hi;
    int dlist[8] = '{0, 1, 2, 3, 4, 5, 6, 9};
    int nlist[4] = '{1, 2, 3, 15};
    rst_n = 1'b0; req_in = 1'b0; req_clr = 1'b0; mode = 2'd0;
    pulse_cnt = 4'd1; div_val = 12'd33; pre_sel = 2'd2; dly_bypass = 1'b0;
    settle(4);
    check(sysref_out == 1'b0, "R10 reset low", sysref_out, 0);
    settle(3);
    check(sysref_out == 1'b0, "R10 reset held", sysref_out, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3: odd 33 rejected, reset value 32 with pre 4 stays in force
    settle(300);
    measure(hi, per);
    check(per == 128, "R3 reset divide period", per, 128);
    check(hi == 64, "R3 reset divide high", hi, 64);

    // R1 / R2 sweep
    dly_bypass = 1'b1;
    for (int ps = 0; ps < 4; ps++) begin
      for (int k = 0; k < 8; k++) begin
        if (ps == 0 && dlist[k] < 2) continue;
        pre_sel = ps[1:0];
        div_val = 12'(dlist[k]);
        pre = 1 << ps;
        de  = (dlist[k] < 1) ? 1 : dlist[k];
        exp_hi = (de >= 2) ? pre * (de / 2) : 1;
        settle(3 * pre * de + 10);
        measure(hi, per);
        if (de >= 2) begin
          check(per == pre * de, "R1 period", per, pre * de);
          check(hi == exp_hi, "R1 high time", hi, exp_hi);
        end else begin
          check(per == pre, "R2 period", per, pre);
          check(hi == 1, "R2 high time", hi, 1);
        end
      end
    end

    // R3 rejection without bypass
    dly_bypass = 1'b0; pre_sel = 2'd0; div_val = 12'd6;
    settle(40);
    div_val = 12'd7;
    settle(40);
    measure(hi, per);
    check(per == 6, "R3 odd rejected period", per, 6);
    dly_bypass = 1'b1;
    settle(40);
    measure(hi, per);
    check(per == 7, "R3 odd accepted with bypass", per, 7);
    check(hi == 3, "R3 odd high time", hi, 3);

    // Burst mode, divider period 4, high 2
    dly_bypass = 1'b0; div_val = 12'd4; pre_sel = 2'd0; mode = 2'd1;
    settle(20);
    run_window(30, 100, 100, 100, 100, rises, highs);
    check(rises == 0, "R4 idle burst no pulses", rises, 0);
    foreach (nlist[k]) begin
      pulse_cnt = 4'(nlist[k]);
      run_window((nlist[k] + 3) * 4 + 20, 0, 3, 100000, 100000, rises, highs);
      check(rises == nlist[k], "R4 burst pulse count", rises, nlist[k]);
      check(highs == 2 * nlist[k], "R4 burst full width", highs, 2 * nlist[k]);
      settle(10);
    end
    pulse_cnt = 4'd0;
    run_window(40, 0, 3, 100000, 100000, rises, highs);
    check(rises == 0, "R5 zero count", rises, 0);
    pulse_cnt = 4'd4;
    run_window(60, 0, 3, 8, 11, rises, highs);
    check(rises == 4, "R6 request during burst ignored", rises, 4);
    check(highs == 8, "R6 burst width kept", highs, 8);
    settle(10);
    req_clr = 1'b1; pulse_cnt = 4'd3;
    run_window(50, 0, 4, 100000, 100000, rises, highs);
    check(rises == 0, "R7 clear blocks request", rises, 0);
    req_clr = 1'b0;
    settle(5);
    run_window(50, 0, 4, 100000, 100000, rises, highs);
    check(rises == 3, "R7 request after clear released", rises, 3);

    // Repeater mode, clear asserted and ignored
    mode = 2'd2; req_clr = 1'b1;
    settle(10);
    @(negedge clk); req_in = 1'b1;
    @(negedge clk);
    check(sysref_out == 1'b0, "R8 latency cycle 1", sysref_out, 0);
    @(negedge clk);
    check(sysref_out == 1'b0, "R8 latency cycle 2", sysref_out, 0);
    @(negedge clk);
    check(sysref_out == 1'b1, "R8 latency cycle 3", sysref_out, 1);
    req_in = 1'b0;
    settle(10);
    run_window(30, 0, 5, 100000, 100000, rises, highs);
    check(rises == 1, "R8 one pulse per request", rises, 1);
    check(highs == 5, "R8 pulse width follows request", highs, 5);

    // Off mode
    req_clr = 1'b0; mode = 2'd3;
    settle(5);
    run_window(40, 2, 8, 15, 20, rises, highs);
    check(highs == 0, "R9 off mode low", highs, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule